// File: doc/BRIEF.md
# Slot-Table Hardware Thread Issue Scheduler

This block decides, once per clock, which of eight hardware threads may issue an instruction into a shared pipeline. It works from two configuration registers. The first is a table of eight issue slots, each four bits wide. The second is a two-bit mode for every thread. The scheduler walks the enabled slots in a fixed circular order. A slot that names an active thread gives the cycle to that thread. A hard-timed thread that owns slots therefore issues at a constant, predictable rate.

Some slots fall back instead. These are slots marked as shared, and slots whose named thread is asleep. Such a slot gives its cycle to the next active soft thread, and a second round-robin pointer over the soft threads picks it. Cycles that would otherwise sit idle are reclaimed for throughput work this way, and the hard threads' rates are not disturbed. Both configuration registers are written through simple write-enable ports. Their contents and the two round-robin pointers are visible at the outputs.

Top module: `hw_thread_slot_sched`

## Requirements
- R1: While `rst_n` is low, `issue_valid` is 0 and `issue_tid` is 0. Both `last_slot` and `last_soft` read 7. `slot_cfg` reads 32'hFFFF_FFF0, so slot 0 names thread 0 and every other slot is disabled. `mode_cfg` reads 16'hFFFC, so thread 0 is active hard and every other thread is sleeping soft.
- R2: Slot i occupies `slot_cfg[4i+3:4i]`. Values 0 to 7 name a thread, 4'hE marks a shared slot, and 4'hF or any value from 8 to 4'hD marks the slot disabled. Each decision picks the first enabled slot found by searching upward from `last_slot`+1, wrapping modulo 8. `last_slot` becomes that slot whenever any slot is enabled.
- R3: If no slot is enabled, the decision is idle. `issue_valid` is 0, `issue_tid` is 0, and both pointers hold their values.
- R4: Thread t's mode occupies `mode_cfg[2t+1:2t]`, encoded as 0 active hard, 1 active soft, 2 sleeping hard and 3 sleeping soft. If the picked slot names a thread whose mode is 0 or 1, that thread issues.
- R5: A picked slot falls back if it is shared or names a sleeping thread. The issued thread is then the first thread in mode 1 found by searching upward from `last_soft`+1, wrapping modulo 8.
- R6: `last_soft` changes only when a fallback issues a soft thread, and it then equals the issued thread. A direct issue of a mode-1 thread leaves it unchanged.
- R7: If a fallback finds no thread in mode 1, nothing issues that cycle, but `last_slot` still advances to the picked slot.
- R8: The decision is registered. A write through `slot_we` or `mode_we` changes `slot_cfg` or `mode_cfg` at the same edge. It first steers the decision that appears at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| slot_we | input | 1 | Write enable for the slot table |
| slot_wdata | input | 32 | New slot table contents |
| mode_we | input | 1 | Write enable for the thread modes |
| mode_wdata | input | 16 | New thread mode contents |
| issue_tid | output | 3 | Thread granted this cycle |
| issue_valid | output | 1 | A thread is granted this cycle |
| slot_cfg | output | 32 | Current slot table |
| mode_cfg | output | 16 | Current thread modes |
| last_slot | output | 3 | Slot used by the most recent decision |
| last_soft | output | 3 | Soft thread most recently granted through fallback |

## Verification
The hardest case to reach is the interplay between the two pointers. A shared slot, or one that names a sleeping thread, must hand over to the soft rotation. Meanwhile a slot naming a soft thread directly must issue that thread and leave the soft pointer where it was. The stimulus reaches this with directed tables that mix direct soft slots, shared slots and sleeping owners. It then runs long stretches of pseudo-random slot and mode rewrites, including undefined codes and tables with nothing enabled. A cycle-level model in the bench predicts every grant and both pointers.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Width of one slot table entry
  localparam int FIELD_W = 4;

  // Slot entry codes that do not name a thread
  localparam logic [FIELD_W-1:0] SLOT_SHARED = 4'hE;
  localparam logic [FIELD_W-1:0] SLOT_OFF    = 4'hF;

  // Per-thread mode: bit 1 = asleep, bit 0 = soft
  typedef enum logic [1:0] {
    MODE_HA = 2'd0,
    MODE_SA = 2'd1,
    MODE_HZ = 2'd2,
    MODE_SZ = 2'd3
  } thr_mode_e;

endpackage

// File: rtl/sched_cfg_regs.sv
module sched_cfg_regs
  import sched_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NSLOT = 8,
  parameter int FW    = FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_we,
  input  logic [NSLOT*FW-1:0]   slot_wdata,
  input  logic                  mode_we,
  input  logic [2*NTHR-1:0]     mode_wdata,
  output logic [NSLOT*FW-1:0]   slot_q,
  output logic [2*NTHR-1:0]     mode_q
);

  localparam int SLOT_W = NSLOT * FW;
  localparam int MODE_W = 2 * NTHR;

  logic [SLOT_W-1:0] slot_rst;
  logic [MODE_W-1:0] mode_rst;
  logic [SLOT_W-1:0] slot_d;
  logic [MODE_W-1:0] mode_d;

  // Reset image: slot 0 owned by thread 0, rest disabled
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot_rst
    if (s == 0) begin : g_first
      assign slot_rst[s*FW +: FW] = '0;
    end else begin : g_rest
      assign slot_rst[s*FW +: FW] = FW'(SLOT_OFF);
    end
  end

  // Reset image: thread 0 active hard, rest sleeping soft
  for (genvar t = 0; t < NTHR; t++) begin : g_mode_rst
    if (t == 0) begin : g_first
      assign mode_rst[2*t +: 2] = MODE_HA;
    end else begin : g_rest
      assign mode_rst[2*t +: 2] = MODE_SZ;
    end
  end

  // Next-state
  always_comb begin
    slot_d = slot_wdata;
    mode_d = mode_wdata;
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= slot_rst;
    end else if (slot_we) begin
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mode_rst;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/sched_slot_classify.sv
module sched_slot_classify
  import sched_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NSLOT = 8,
  parameter int FW    = FIELD_W
) (
  input  logic [NSLOT*FW-1:0]                   slot_i,
  input  logic [2*NTHR-1:0]                     mode_i,
  output logic [NSLOT-1:0]                      slot_en_o,
  output logic [NSLOT-1:0]                      slot_tid_o,
  output logic [NSLOT-1:0][$clog2(NTHR)-1:0]    slot_name_o,
  output logic [NTHR-1:0]                       thr_act_o,
  output logic [NTHR-1:0]                       thr_soft_o
);

  localparam int TW = $clog2(NTHR);

  // Per-slot decode: thread id, shared, or disabled
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [FW-1:0] field;
    logic          is_tid;
    logic          is_shared;

    always_comb begin
      field          = slot_i[s*FW +: FW];
      is_tid         = (field < FW'(NTHR));
      is_shared      = (field == FW'(SLOT_SHARED));
      slot_tid_o[s]  = is_tid;
      slot_en_o[s]   = is_tid | is_shared;
      slot_name_o[s] = field[TW-1:0];
    end
  end

  // Per-thread decode of the mode field
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [1:0] m;

    always_comb begin
      m             = mode_i[2*t +: 2];
      thr_act_o[t]  = ~m[1];
      thr_soft_o[t] = (m == MODE_SA);
    end
  end

endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]         mask_i,
  input  logic [$clog2(N)-1:0] last_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);

  localparam int IW = $clog2(N);

  // Searches upward from last_i+1 with wrap; nearest set bit wins
  always_comb begin
    found_o = |mask_i;
    idx_o   = last_i;
    for (int k = N; k >= 1; k--) begin
      int pos;
      pos = (int'(last_i) + k) % N;
      if (mask_i[pos]) begin
        idx_o = IW'(pos);
      end
    end
  end

endmodule

// File: rtl/hw_thread_slot_sched.sv
module hw_thread_slot_sched
  import sched_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NSLOT = 8,
  parameter int FW    = FIELD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      slot_we,
  input  logic [NSLOT*FW-1:0]       slot_wdata,
  input  logic                      mode_we,
  input  logic [2*NTHR-1:0]         mode_wdata,
  output logic [$clog2(NTHR)-1:0]   issue_tid,
  output logic                      issue_valid,
  output logic [NSLOT*FW-1:0]       slot_cfg,
  output logic [2*NTHR-1:0]         mode_cfg,
  output logic [$clog2(NSLOT)-1:0]  last_slot,
  output logic [$clog2(NSLOT)-1:0]  last_soft
);

  localparam int TW     = $clog2(NTHR);
  localparam int SW     = $clog2(NSLOT);
  localparam int SLOT_W = NSLOT * FW;
  localparam int MODE_W = 2 * NTHR;

  // Configuration state
  logic [SLOT_W-1:0] slot_q;
  logic [MODE_W-1:0] mode_q;

  // Decoded table
  logic [NSLOT-1:0]          slot_en;
  logic [NSLOT-1:0]          slot_tid;
  logic [NSLOT-1:0][TW-1:0]  slot_name;
  logic [NTHR-1:0]           thr_act;
  logic [NTHR-1:0]           thr_soft;

  // Round-robin results
  logic          slot_found;
  logic [SW-1:0] slot_sel;
  logic          soft_found;
  logic [TW-1:0] soft_sel;

  // Pointer and issue state
  logic [SW-1:0] ls_q, ls_d;
  logic [TW-1:0] lt_q, lt_d;
  logic          ls_en, lt_en;
  logic [TW-1:0] tid_q, tid_d;
  logic          vld_q, vld_d;

  // Decision intermediates
  logic [TW-1:0] named;
  logic          direct;
  logic          fallback;

  sched_cfg_regs #(
    .NTHR  (NTHR),
    .NSLOT (NSLOT),
    .FW    (FW)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_we    (slot_we),
    .slot_wdata (slot_wdata),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .slot_q     (slot_q),
    .mode_q     (mode_q)
  );

  sched_slot_classify #(
    .NTHR  (NTHR),
    .NSLOT (NSLOT),
    .FW    (FW)
  ) u_cls (
    .slot_i      (slot_q),
    .mode_i      (mode_q),
    .slot_en_o   (slot_en),
    .slot_tid_o  (slot_tid),
    .slot_name_o (slot_name),
    .thr_act_o   (thr_act),
    .thr_soft_o  (thr_soft)
  );

  sched_rr_pick #(
    .N (NSLOT)
  ) u_slot_rr (
    .mask_i  (slot_en),
    .last_i  (ls_q),
    .found_o (slot_found),
    .idx_o   (slot_sel)
  );

  sched_rr_pick #(
    .N (NTHR)
  ) u_soft_rr (
    .mask_i  (thr_soft),
    .last_i  (lt_q),
    .found_o (soft_found),
    .idx_o   (soft_sel)
  );

  // Issue decision
  always_comb begin
    named    = slot_name[slot_sel];
    direct   = slot_found & slot_tid[slot_sel] & thr_act[named];
    fallback = slot_found & ~direct;

    ls_en = slot_found;
    ls_d  = slot_sel;
    lt_en = fallback & soft_found;
    lt_d  = soft_sel;

    vld_d = direct | (fallback & soft_found);
    if (direct) begin
      tid_d = named;
    end else if (fallback & soft_found) begin
      tid_d = soft_sel;
    end else begin
      tid_d = '0;
    end
  end

  // Pointers start at the top index so index 0 is examined first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q <= SW'(NSLOT - 1);
    end else if (ls_en) begin
      ls_q <= ls_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_q <= TW'(NTHR - 1);
    end else if (lt_en) begin
      lt_q <= lt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tid_q <= '0;
    end else begin
      vld_q <= vld_d;
      tid_q <= tid_d;
    end
  end

  assign issue_valid = vld_q;
  assign issue_tid   = tid_q;
  assign slot_cfg    = slot_q;
  assign mode_cfg    = mode_q;
  assign last_slot   = ls_q;
  assign last_soft   = lt_q;

endmodule

// File: rtl/hw_thread_slot_sched_chk.sv
module hw_thread_slot_sched_chk
  import sched_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NSLOT = 8,
  parameter int FW    = FIELD_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [$clog2(NTHR)-1:0]   issue_tid,
  input logic                      issue_valid,
  input logic [NSLOT*FW-1:0]       slot_cfg,
  input logic [2*NTHR-1:0]         mode_cfg,
  input logic [$clog2(NSLOT)-1:0]  last_slot,
  input logic [$clog2(NSLOT)-1:0]  last_soft
);

  localparam int TW = $clog2(NTHR);

  // Configuration the most recent decision was made from
  logic [NSLOT*FW-1:0] prev_slot;
  logic [2*NTHR-1:0]   prev_mode;
  logic                primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_slot <= '0;
      prev_mode <= '0;
      primed    <= 1'b0;
    end else begin
      prev_slot <= slot_cfg;
      prev_mode <= mode_cfg;
      primed    <= 1'b1;
    end
  end

  logic [FW-1:0] pf;
  logic          pf_tid;
  logic          pf_en;
  logic          pf_active;
  logic          tid_was_active;
  logic          tid_was_soft;
  logic          prev_none;

  always_comb begin
    pf             = prev_slot[int'(last_slot)*FW +: FW];
    pf_tid         = (pf < FW'(NTHR));
    pf_en          = pf_tid | (pf == FW'(SLOT_SHARED));
    pf_active      = ~prev_mode[2*int'(pf[TW-1:0]) + 1];
    tid_was_active = ~prev_mode[2*int'(issue_tid) + 1];
    tid_was_soft   = (prev_mode[2*int'(issue_tid) +: 2] == MODE_SA);
    prev_none      = 1'b1;
    for (int s = 0; s < NSLOT; s++) begin
      if ((prev_slot[s*FW +: FW] < FW'(NTHR)) ||
          (prev_slot[s*FW +: FW] == FW'(SLOT_SHARED))) begin
        prev_none = 1'b0;
      end
    end
  end

  AST_GRANT_NEEDS_ENABLED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && issue_valid) |-> pf_en); // R2

  AST_EMPTY_TABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && prev_none) |-> (!issue_valid && last_slot == $past(last_slot)
                               && last_soft == $past(last_soft))); // R3

  AST_GRANT_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && issue_valid) |-> tid_was_active); // R4

  AST_OWNER_ISSUES_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && pf_tid && pf_active) |-> (issue_valid && issue_tid == pf[TW-1:0])); // R4

  AST_FALLBACK_GIVES_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && issue_valid && !(pf_tid && pf_active)) |-> tid_was_soft); // R5

  AST_SOFT_PTR_MOVES_ON_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && last_soft != $past(last_soft)) |->
      (issue_valid && issue_tid == last_soft && tid_was_soft)); // R6

endmodule

bind hw_thread_slot_sched hw_thread_slot_sched_chk #(
  .NTHR  (NTHR),
  .NSLOT (NSLOT),
  .FW    (FW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_tid   (issue_tid),
  .issue_valid (issue_valid),
  .slot_cfg    (slot_cfg),
  .mode_cfg    (mode_cfg),
  .last_slot   (last_slot),
  .last_soft   (last_soft)
);

// File: tb/sim_hw_thread_slot_sched.sv
module sim_hw_thread_slot_sched;

  logic        clk;
  logic        rst_n;
  logic        slot_we;
  logic [31:0] slot_wdata;
  logic        mode_we;
  logic [15:0] mode_wdata;
  logic [2:0]  issue_tid;
  logic        issue_valid;
  logic [31:0] slot_cfg;
  logic [15:0] mode_cfg;
  logic [2:0]  last_slot;
  logic [2:0]  last_soft;

  hw_thread_slot_sched u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_we     (slot_we),
    .slot_wdata  (slot_wdata),
    .mode_we     (mode_we),
    .mode_wdata  (mode_wdata),
    .issue_tid   (issue_tid),
    .issue_valid (issue_valid),
    .slot_cfg    (slot_cfg),
    .mode_cfg    (mode_cfg),
    .last_slot   (last_slot),
    .last_soft   (last_soft)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  typedef struct {
    bit        v;
    bit [2:0]  tid;
    bit [2:0]  ls;
    bit [2:0]  lt;
    bit [31:0] sc;
    bit [15:0] mc;
    string     req;
  } exp_t;

  exp_t sb[$];

  // Reference state, built from the requirements
  bit [3:0] m_slot [8];
  bit [1:0] m_mode [8];
  int       m_ls;
  int       m_lt;

  function automatic bit [31:0] pack_slot();
    bit [31:0] w;
    for (int i = 0; i < 8; i++) w[4*i +: 4] = m_slot[i];
    return w;
  endfunction

  function automatic bit [15:0] pack_mode();
    bit [15:0] w;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = m_mode[i];
    return w;
  endfunction

  function automatic bit slot_enabled(bit [3:0] f);
    return (f < 4'd8) || (f == 4'hE);
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input bit sw, input bit [31:0] sd,
                      input bit mw, input bit [15:0] md, input string tag);
    exp_t     e;
    bit       sf;
    int       s;
    bit       tf;
    int       t;
    bit [3:0] f;
    @(negedge clk);
    slot_we    = sw;
    slot_wdata = sd;
    mode_we    = mw;
    mode_wdata = md;
    sf = 0; s = 0;
    for (int k = 8; k >= 1; k--) begin
      int p;
      p = (m_ls + k) % 8;
      if (slot_enabled(m_slot[p])) begin sf = 1; s = p; end
    end
    tf = 0; t = 0;
    for (int k = 8; k >= 1; k--) begin
      int p;
      p = (m_lt + k) % 8;
      if (m_mode[p] == 2'd1) begin tf = 1; t = p; end
    end
    e.v = 0; e.tid = 0;
    if (sf) begin
      f    = m_slot[s];
      m_ls = s;
      if (f < 4'd8 && !m_mode[f[2:0]][1]) begin
        e.v = 1; e.tid = f[2:0];
      end else if (tf) begin
        e.v = 1; e.tid = 3'(t); m_lt = t;
      end
    end
    if (sw) for (int i = 0; i < 8; i++) m_slot[i] = sd[4*i +: 4];
    if (mw) for (int i = 0; i < 8; i++) m_mode[i] = md[2*i +: 2];
    e.ls  = 3'(m_ls);
    e.lt  = 3'(m_lt);
    e.sc  = pack_slot();
    e.mc  = pack_mode();
    e.req = tag;
    @(posedge clk);
    #1;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 32'h0, 0, 16'h0, tag);
  endtask

  // Monitor: pops each expected item once the design has latched it
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (issue_valid !== e.v || issue_tid !== e.tid || last_slot !== e.ls ||
            last_soft !== e.lt || slot_cfg !== e.sc || mode_cfg !== e.mc) begin
          bad++;
          $display("FAIL %s: got v=%0b tid=%0d ls=%0d lt=%0d slot=%h mode=%h exp v=%0b tid=%0d ls=%0d lt=%0d slot=%h mode=%h",
                   e.req, issue_valid, issue_tid, last_slot, last_soft, slot_cfg, mode_cfg,
                   e.v, e.tid, e.ls, e.lt, e.sc, e.mc);
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    bit [31:0] lfsr;
    rst_n      = 1'b0;
    slot_we    = 1'b0;
    slot_wdata = '0;
    mode_we    = 1'b0;
    mode_wdata = '0;
    for (int i = 0; i < 8; i++) begin
      m_slot[i] = (i == 0) ? 4'h0 : 4'hF;
      m_mode[i] = (i == 0) ? 2'd0 : 2'd3;
    end
    m_ls = 7;
    m_lt = 7;
    repeat (3) @(negedge clk);

    // R1: reset state, sampled before the first edge after release
    total++;
    if (issue_valid !== 1'b0 || issue_tid !== 3'd0 || last_slot !== 3'd7 ||
        last_soft !== 3'd7 || slot_cfg !== 32'hFFFF_FFF0 || mode_cfg !== 16'hFFFC) begin
      bad++;
      $display("FAIL R1: got v=%0b tid=%0d ls=%0d lt=%0d slot=%h mode=%h exp v=0 tid=0 ls=7 lt=7 slot=ffff_fff0 mode=fffc",
               issue_valid, issue_tid, last_slot, last_soft, slot_cfg, mode_cfg);
    end
    rst_n = 1'b1;

    // R4: thread 0 alone, from the reset table
    idle(4, "R4");

    // R8: table write with shared slots and a sleeping owner, same-edge readback
    step(1, 32'hFFE2_F1E0, 1, 16'hFD48, "R8");
    // R5: fallback rotates over soft threads 3 and 4
    idle(16, "R5");

    // R6: slots naming soft thread 3 directly, mixed with shared slots
    step(1, 32'hFFFF_FE33, 0, 16'h0, "R6");
    idle(12, "R6");

    // R7: no active soft thread, fallbacks go idle while slot pointer moves
    step(0, 32'h0, 1, 16'hFFC8, "R7");
    idle(10, "R7");

    // R3: every slot disabled
    step(1, 32'hFFFF_FFFF, 0, 16'h0, "R3");
    idle(5, "R3");

    // R2: undefined codes 8..D count as disabled
    step(1, 32'hDCBA_98DC, 0, 16'h0, "R2");
    idle(4, "R2");
    // R2: single enabled slot at the top index among undefined codes
    step(1, 32'hE9AB_CD98, 1, 16'h7FFF, "R2");
    idle(6, "R2");

    // R8: back-to-back rewrites each steer the next decision
    step(1, 32'h7654_3210, 1, 16'h0000, "R8");
    step(1, 32'hEEEE_EEEE, 1, 16'h5555, "R8");
    step(1, 32'h0123_4567, 1, 16'hAAAA, "R8");
    idle(9, "R8");

    // R5: pseudo-random tables and modes
    lfsr = 32'h1D2C_3B4A;
    for (int n = 0; n < 600; n++) begin
      bit sw;
      bit mw;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sw = (lfsr[3:0] == 4'd0);
      mw = (lfsr[7:4] == 4'd1);
      step(sw, {lfsr[15:0], lfsr[31:16]}, mw, lfsr[27:12], "R5");
    end

    @(negedge clk);
    #1;
    finish_run();
  end

endmodule